// File: doc/BRIEF.md
# Vertical Frame Period Meter

This block times the interval between successive active edges of a vertical sync input. The time unit is a fixed tick of PRESCALE bus clock cycles, which is 8 µs at the nominal bus clock with the default of 16. At every active frame edge, the number of whole ticks seen during the frame just ended is loaded into a pair of read-only byte registers. Firmware turns that value into a frame rate (roughly the reciprocal of ticks × tick time) and uses it to classify the incoming video timing.

A saturating tick counter limits the measurable period. With the defaults, the limit is 8096 ticks, about 64.8 ms. When a frame runs past the limit, an overflow flag in the top bit of the high byte is set at once, without waiting for a frame edge. This lets firmware spot a missing or very slow vertical sync while it is still happening. The flag is reloaded at every frame edge. A polarity input chooses whether rising or falling edges mark a frame.

Reading is split across the two bytes. A read strobe on the high byte copies the current low period byte into a hold register, and the low byte output always shows that hold register. A high-then-low read sequence therefore always returns two halves of the same frame, even when a frame edge falls between the two reads.

Top module: `vfp_meter`

## Requirements
- R1: After reset the high byte, the low byte and the overflow flag all read zero.
- R2: The period counter restarts at each active edge and advances once every PRESCALE clocks. When active edges are N clocks apart, the captured period equals floor((N-1)/PRESCALE).
- R3: The sync input passes through a two-stage synchroniser and one edge-detect stage. The captured period reaches the outputs on the third rising clock edge that samples the new sync level, and not earlier.
- R4: When vsync_pol is 1, only rising sync edges mark a frame. When vsync_pol is 0, only falling edges mark a frame. Edges of the other direction have no effect on the measurement.
- R5: The period counter saturates at LIMIT and does not wrap. An overflowed frame captures the value LIMIT.
- R6: The overflow flag (high byte bit 7) goes to 1 within one clock of the running count reaching LIMIT, without waiting for a frame edge.
- R7: At each frame edge the overflow flag is reloaded from that frame: it is cleared when the frame ended below LIMIT ticks and stays set when it reached LIMIT.
- R8: The byte layout is fixed. The high byte holds the overflow flag in bit 7, zeros in bits 6:5, and period bits 12:8 in bits 4:0. The low byte shows a hold register that is loaded with period bits 7:0 only on a clock where hi_rd is high, and it keeps its value across frame edges.
- R9: A frame of exactly LIMIT-1 ticks captures LIMIT-1 and leaves the overflow flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vsync_in | input | 1 | Vertical sync, asynchronous to clk |
| vsync_pol | input | 1 | 1: rising edge marks a frame, 0: falling edge |
| hi_rd | input | 1 | Read strobe of the high byte; latches the low byte |
| hi_data | output | BYTE_W (8) | Overflow flag and upper period bits |
| lo_data | output | BYTE_W (8) | Low period bits as latched by the last high read |

## Verification
The bench targets the edges of the counting range:
- A frame of LIMIT-1 ticks must capture LIMIT-1 with the flag clear, and one more clock must set the flag. An off-by-one limit compare fails one of these two checks.
- A long frame is probed just before and just after the count reaches LIMIT. A design that raises the overflow flag only at the frame edge fails the second probe. A design that wraps the counter instead of saturating captures a small value rather than LIMIT.
- With falling polarity, each frame contains a rising transition in the middle. A design that reacts to both edges captures a far shorter period.
- A high read is followed by a new frame before the low byte is read. A design whose low byte follows the live period mixes bytes from two frames.
- The latency probe catches a capture that arrives one cycle early or late.

// File: rtl/vfp_pkg.sv
package vfp_pkg;

   typedef enum logic {
      VFP_EDGE_FALL = 1'b0,
      VFP_EDGE_RISE = 1'b1
   } vfp_pol_e;

   function automatic bit vfp_is_pow2(input int unsigned v);
      return (v != 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/vfp_sync_edge.sv
module vfp_sync_edge
   import vfp_pkg::*;
#(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic vs_async,
   input  logic pol,
   output logic frame_edge
);

   logic [STAGES-1:0] chain;
   logic              lvl;
   logic              lvl_d;
   vfp_pol_e          pol_e;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= 1'b0;
               else        chain[gi] <= vs_async;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= 1'b0;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   assign lvl = chain[STAGES-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) lvl_d <= 1'b0;
      else        lvl_d <= lvl;
   end

   assign pol_e = vfp_pol_e'(pol);

   always_comb begin
      if (pol_e == VFP_EDGE_RISE) frame_edge = lvl & ~lvl_d;
      else                        frame_edge = ~lvl & lvl_d;
   end

   AST_EDGE_SINGLE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_edge && $stable(pol)) |=> !frame_edge); // R3

endmodule

// File: rtl/vfp_tick_gen.sv
module vfp_tick_gen
   import vfp_pkg::*;
#(
   parameter int unsigned PRESCALE = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic restart,
   output logic tick
);

   localparam int unsigned PW = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

   logic [PW-1:0] pre;

   generate
      if (vfp_is_pow2(PRESCALE)) begin : g_pow2
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       pre <= '0;
            else if (restart) pre <= '0;
            else              pre <= pre + 1'b1;
         end
         assign tick = &pre;
      end else begin : g_generic
         localparam logic [PW-1:0] LAST = PW'(PRESCALE - 1);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)            pre <= '0;
            else if (restart)      pre <= '0;
            else if (pre == LAST)  pre <= '0;
            else                   pre <= pre + 1'b1;
         end
         assign tick = (pre == LAST);
      end
   endgenerate

   AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
      tick |=> !tick); // R2

endmodule

// File: rtl/vfp_period_cnt.sv
module vfp_period_cnt #(
   parameter int unsigned CNT_W = 13,
   parameter int unsigned LIMIT = 8096
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic             tick,
   output logic [CNT_W-1:0] count,
   output logic             at_limit,
   output logic             hit_limit
);

   localparam logic [CNT_W-1:0] LIM    = CNT_W'(LIMIT);
   localparam logic [CNT_W-1:0] LIM_M1 = CNT_W'(LIMIT - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                      cnt_q <= '0;
      else if (restart)                cnt_q <= '0;
      else if (tick && cnt_q != LIM)   cnt_q <= cnt_q + 1'b1;
   end

   assign count     = cnt_q;
   assign at_limit  = (cnt_q == LIM);
   assign hit_limit = tick && !restart && (cnt_q == LIM_M1);

   AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= LIM); // R5
   AST_CNT_HOLDS_AT_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      (at_limit && !restart) |=> at_limit); // R5

endmodule

// File: rtl/vfp_regs.sv
module vfp_regs #(
   parameter int unsigned CNT_W  = 13,
   parameter int unsigned BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              frame_edge,
   input  logic [CNT_W-1:0]  count,
   input  logic              at_limit,
   input  logic              hit_limit,
   input  logic              hi_rd,
   output logic [BYTE_W-1:0] hi_data,
   output logic [BYTE_W-1:0] lo_data
);

   localparam int unsigned HI_BITS = CNT_W - BYTE_W;
   localparam int unsigned PAD     = BYTE_W - 1 - HI_BITS;

   logic [CNT_W-1:0]  per_q;
   logic              vof_q;
   logic [BYTE_W-1:0] lo_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         per_q <= '0;
         vof_q <= 1'b0;
      end else if (frame_edge) begin
         per_q <= count;
         vof_q <= at_limit;
      end else if (hit_limit) begin
         vof_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     lo_hold <= '0;
      else if (hi_rd) lo_hold <= per_q[BYTE_W-1:0];
   end

   generate
      if (PAD > 0) begin : g_padded
         assign hi_data = {vof_q, {PAD{1'b0}}, per_q[CNT_W-1:BYTE_W]};
      end else begin : g_packed
         assign hi_data = {vof_q, per_q[CNT_W-1:BYTE_W]};
      end
   endgenerate

   assign lo_data = lo_hold;

   AST_VOF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (vof_q && !frame_edge) |=> vof_q); // R6
   AST_VOF_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_limit && !frame_edge) |=> hi_data[BYTE_W-1]); // R6
   AST_LO_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      !hi_rd |=> $stable(lo_data)); // R8

endmodule

// File: rtl/vfp_meter.sv
module vfp_meter #(
   parameter int unsigned CNT_W       = 13,
   parameter int unsigned BYTE_W      = 8,
   parameter int unsigned PRESCALE    = 16,
   parameter int unsigned LIMIT       = 8096,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              vsync_in,
   input  logic              vsync_pol,
   input  logic              hi_rd,
   output logic [BYTE_W-1:0] hi_data,
   output logic [BYTE_W-1:0] lo_data
);

   generate
      if (CNT_W <= BYTE_W || CNT_W > 2 * BYTE_W - 1) begin : g_bad_width
         $error("vfp_meter: CNT_W must exceed BYTE_W and leave room for the flag");
      end
      if (LIMIT < 2 || LIMIT >= (1 << CNT_W)) begin : g_bad_limit
         $error("vfp_meter: LIMIT must fit in CNT_W bits");
      end
      if (PRESCALE < 2) begin : g_bad_prescale
         $error("vfp_meter: PRESCALE must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("vfp_meter: SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             frame_edge;
   logic             tick;
   logic [CNT_W-1:0] count;
   logic             at_limit;
   logic             hit_limit;

   vfp_sync_edge #(.STAGES(SYNC_STAGES)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .vs_async   (vsync_in),
      .pol        (vsync_pol),
      .frame_edge (frame_edge)
   );

   vfp_tick_gen #(.PRESCALE(PRESCALE)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (frame_edge),
      .tick    (tick)
   );

   vfp_period_cnt #(.CNT_W(CNT_W), .LIMIT(LIMIT)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .restart   (frame_edge),
      .tick      (tick),
      .count     (count),
      .at_limit  (at_limit),
      .hit_limit (hit_limit)
   );

   vfp_regs #(.CNT_W(CNT_W), .BYTE_W(BYTE_W)) u_regs (
      .clk        (clk),
      .rst_n      (rst_n),
      .frame_edge (frame_edge),
      .count      (count),
      .at_limit   (at_limit),
      .hit_limit  (hit_limit),
      .hi_rd      (hi_rd),
      .hi_data    (hi_data),
      .lo_data    (lo_data)
   );

   AST_EDGE_RELOADS_VOF: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_edge && !at_limit) |=> !hi_data[BYTE_W-1]); // R7

endmodule

// File: tb/tb_vfp_meter.sv
`timescale 1ns/1ps
module tb_vfp_meter;

   localparam int unsigned CNT_W    = 13;
   localparam int unsigned BYTE_W   = 8;
   localparam int unsigned PRESCALE = 4;
   localparam int unsigned LIMIT    = 400;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic vsync_in = 1'b0;
   logic vsync_pol = 1'b1;
   logic hi_rd = 1'b0;
   logic [BYTE_W-1:0] hi_data;
   logic [BYTE_W-1:0] lo_data;

   int vectors = 0;
   int miscompares = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   vfp_meter #(
      .CNT_W(CNT_W), .BYTE_W(BYTE_W), .PRESCALE(PRESCALE),
      .LIMIT(LIMIT), .SYNC_STAGES(2)
   ) dut (
      .clk(clk), .rst_n(rst_n), .vsync_in(vsync_in), .vsync_pol(vsync_pol),
      .hi_rd(hi_rd), .hi_data(hi_data), .lo_data(lo_data)
   );

   task automatic check(input string req, input logic [BYTE_W-1:0] act,
                        input logic [BYTE_W-1:0] exp);
      vectors++;
      if (act !== exp) begin
         miscompares++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   function automatic logic [BYTE_W-1:0] hi_of(input int v, input bit vof);
      logic [CNT_W-1:0] p;
      p = CNT_W'(v);
      return {vof, 2'b00, p[12:8]};
   endfunction

   function automatic logic active_lvl();
      return vsync_pol;
   endfunction

   task automatic frame(input int n);
      vsync_in = active_lvl();
      repeat (3) @(negedge clk);
      vsync_in = ~active_lvl();
      repeat (n - 3) @(negedge clk);
   endtask

   task automatic close_edge();
      vsync_in = active_lvl();
      repeat (3) @(negedge clk);
      vsync_in = ~active_lvl();
      @(negedge clk);
   endtask

   task automatic measure(input int n);
      frame(n);
      close_edge();
   endtask

   task automatic read_check(input string req, input int v, input bit vof);
      logic [CNT_W-1:0] p;
      p = CNT_W'(v);
      check(req, hi_data, hi_of(v, vof));
      hi_rd = 1'b1;
      @(negedge clk);
      hi_rd = 1'b0;
      check(req, lo_data, p[7:0]);
   endtask

   task automatic t_reset();
      check("R1 hi after reset", hi_data, 8'h00);
      check("R1 lo after reset", lo_data, 8'h00);
   endtask

   task automatic t_basic();
      measure(101);
      read_check("R2 101 clk frame", 25, 1'b0);
      measure(41);
      read_check("R2 41 clk frame", 10, 1'b0);
      measure(1201);
      read_check("R8 split 300", 300, 1'b0);
   endtask

   task automatic t_latency();
      measure(41);
      frame(1201);
      vsync_in = active_lvl();
      @(negedge clk);
      @(negedge clk);
      check("R3 not before third edge", hi_data, 8'h00);
      @(negedge clk);
      check("R3 on third edge", hi_data, 8'h01);
      vsync_in = ~active_lvl();
      @(negedge clk);
   endtask

   task automatic t_polarity();
      vsync_pol = 1'b0;
      vsync_in  = 1'b1;
      repeat (6) @(negedge clk);
      measure(101);
      read_check("R4 falling edges, rising ignored", 25, 1'b0);
      measure(41);
      read_check("R4 falling edges second frame", 10, 1'b0);
      vsync_pol = 1'b1;
      vsync_in  = 1'b0;
      repeat (6) @(negedge clk);
   endtask

   task automatic t_limit();
      measure(1600);
      read_check("R9 LIMIT-1 ticks", LIMIT - 1, 1'b0);
      measure(1601);
      read_check("R5 LIMIT ticks saturate", LIMIT, 1'b1);
      measure(41);
      read_check("R7 short frame clears flag", 10, 1'b0);
   endtask

   task automatic t_midframe();
      vsync_in = 1'b1;
      repeat (3) @(negedge clk);
      vsync_in = 1'b0;
      repeat (1587) @(negedge clk);
      check("R6 flag not early", hi_data[7] ? 8'h01 : 8'h00, 8'h00);
      repeat (20) @(negedge clk);
      check("R6 flag set mid frame", hi_data[7] ? 8'h01 : 8'h00, 8'h01);
      repeat (2500 - 1610) @(negedge clk);
      close_edge();
      read_check("R5 long frame saturates", LIMIT, 1'b1);
      measure(101);
      read_check("R7 flag reloaded clear", 25, 1'b0);
   endtask

   task automatic t_atomic();
      measure(1201);
      read_check("R8 first frame", 300, 1'b0);
      measure(101);
      check("R8 lo held across frame", lo_data, 8'h2C);
      check("R8 hi shows new frame", hi_data, 8'h00);
      hi_rd = 1'b1;
      @(negedge clk);
      hi_rd = 1'b0;
      check("R8 lo after new read", lo_data, 8'h19);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_basic();
      t_latency();
      t_polarity();
      t_limit();
      t_midframe();
      t_atomic();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         vectors++;
         miscompares++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
         $finish;
      end
   end

endmodule